// File: doc/BRIEF.md
# Miscellaneous Status Register with Update Aliases

This block holds one 64-bit control/status word on a register bus that accepts only full 8-byte transfers. The bus carries byte addresses, and the block divides each address by eight to get a word index. The word can be reached at three neighbouring indices. The first index reads and writes the word directly. The next index applies a generation-dependent update. The index after that merges the write data in with a bitwise OR. Only the sixteen most significant bits are stored. The lower 48 bits always read back as zero.

The most significant stored bit is presented as a level interrupt request. It stays asserted for as long as that bit is set, and an OR update is how software raises it. A parameter selects one of two hardware generations. The generations differ in the base index and in what the second index does. In one it combines the word with the write data through AND. In the other it clears the word no matter what data is written.

Every request gets a ready strobe one cycle later, together with the read data. A request to an index the block does not map, or with a transfer size other than eight bytes, returns zero data and pulses an unimplemented-access flag. Such a request leaves the word untouched.

Top module: `misc_status_reg`

## Requirements
- R1: The word index is the byte address shifted right by three. With GEN_B=0 the direct index is 0x4020, the AND index 0x4021 and the OR index 0x4022. With GEN_B=1 the direct index is 0x6080, the clear index 0x6081 and the OR index 0x6082. An index of the other generation is unmapped.
- R2: A direct write stores the write data ANDed with 0xFFFF_0000_0000_0000, so bits 47:0 always read as zero.
- R3: A write to the OR index stores (stored value OR write data) masked to bits 63:48.
- R4: With GEN_B=0, a write to the second index stores (stored value AND write data) masked to bits 63:48.
- R5: With GEN_B=1, a write to the second index stores zero whatever the write data.
- R6: irq_o equals bit 63 of the stored word. It changes on the same clock edge as the word and holds as a level until a later write changes it.
- R7: Every request is answered with rsp_ready_o high for one cycle on the following cycle. A read of the direct index returns the stored word. A read of either alias index returns zero.
- R8: A request to an unmapped index reads as zero, leaves the word unchanged and pulses rsp_unimpl_o for one cycle together with rsp_ready_o.
- R9: A request whose req_size_i is not 8 is handled like an unmapped one: zero data, rsp_unimpl_o pulses, and the word is unchanged even at a mapped index.
- R10: After reset the word is zero, and irq_o, rsp_ready_o and rsp_unimpl_o are low.
- R11: A read at any index never changes the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 4 | Transfer size in bytes |
| req_wdata_i | input | DATA_W | Write data, bit 63 is the MSB |
| rsp_ready_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | DATA_W | Read data, valid with rsp_ready_o |
| rsp_unimpl_o | output | 1 | Unmapped index or bad size, valid with rsp_ready_o |
| irq_o | output | 1 | Level interrupt, equal to the stored bit 63 |

## Verification
Both generations are exercised side by side against one behavioural model. This makes a design that builds the wrong alias variant visible at once: an AND that should be a clear leaves bits set, and a clear that should be an AND wipes the word. Write data full of low-order ones shows any missing mask as non-zero low bits on readback. A falling bit 63 shows an interrupt wired as a pulse, or one that never drops, as a mismatch on irq_o. Each generation is also sent the other generation's indices, plus the indices just below and just above its own window, and a 4-byte write to the direct index. A decoder that is off by one, or that ignores the size field, then corrupts the stored word or fails to raise the unimplemented flag.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_DIRECT,
    OP_ALIAS1,
    OP_OR,
    OP_BAD
  } reg_op_e;

  localparam int unsigned IDX_BASE_A = 32'h4020;
  localparam int unsigned IDX_BASE_B = 32'h6080;
endpackage

// File: rtl/misc_addr_decode.sv
module misc_addr_decode
  import misc_reg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 8,
  parameter bit GEN_B  = 1'b0
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  output reg_op_e           op_o
);
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [IDX_W-1:0] BASE = IDX_W'(GEN_B ? IDX_BASE_B : IDX_BASE_A);

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:3];

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      if (size_i != 4'(BYTES))        op_o = OP_BAD;
      else if (idx == BASE)           op_o = OP_DIRECT;
      else if (idx == BASE + 1'b1)    op_o = OP_ALIAS1;
      else if (idx == BASE + 2'd2)    op_o = OP_OR;
      else                            op_o = OP_BAD;
    end
  end
endmodule

// File: rtl/misc_reg_core.sv
module misc_reg_core
  import misc_reg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16,
  parameter bit GEN_B  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_op_e           op_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] value_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {(DATA_W-KEEP_W){1'b0}}};

  logic [DATA_W-1:0] value_q, alias1_val, next_val;
  logic              upd;

  generate
    if (GEN_B) begin : g_clear
      assign alias1_val = '0;
    end else begin : g_and
      assign alias1_val = value_q & wdata_i;
    end
  endgenerate

  always_comb begin
    upd      = write_i;
    next_val = value_q;
    unique case (op_i)
      OP_DIRECT: next_val = wdata_i;
      OP_ALIAS1: next_val = alias1_val;
      OP_OR:     next_val = value_q | wdata_i;
      default:   upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  value_q <= '0;
    else if (upd) value_q <= next_val & KEEP_MASK;
  end

  assign value_o = value_q;

  AST_READ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_i |=> $stable(value_q)); // R11
  AST_BAD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BAD) |=> $stable(value_q)); // R8
  AST_OR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_OR && write_i) |=> ((value_q & $past(value_q)) == $past(value_q))); // R3

  generate
    if (GEN_B) begin : g_ast_clear
      AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_ALIAS1 && write_i) |=> (value_q == '0)); // R5
    end else begin : g_ast_and
      AST_AND_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_ALIAS1 && write_i) |=> ((value_q & ~$past(value_q)) == '0)); // R4
    end
  endgenerate
endmodule

// File: rtl/misc_status_reg.sv
module misc_status_reg
  import misc_reg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16,
  parameter bit GEN_B  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_unimpl_o,
  output logic              irq_o
);
  localparam int BYTES = DATA_W / 8;

  reg_op_e           op;
  logic [DATA_W-1:0] value;

  misc_addr_decode #(.ADDR_W(ADDR_W), .BYTES(BYTES), .GEN_B(GEN_B)) u_dec (
    .valid_i (req_valid_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .op_o    (op)
  );

  misc_reg_core #(.DATA_W(DATA_W), .KEEP_W(KEEP_W), .GEN_B(GEN_B)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .write_i (req_write_i),
    .wdata_i (req_wdata_i),
    .value_o (value)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_ready_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      rsp_unimpl_o <= 1'b0;
    end else begin
      rsp_ready_o  <= req_valid_i;
      rsp_unimpl_o <= (op == OP_BAD);
      rsp_rdata_o  <= (op == OP_DIRECT && !req_write_i) ? value : '0;
    end
  end

  assign irq_o = value[DATA_W-1];

  AST_READY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_ready_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_ready_o && !rsp_unimpl_o)); // R8
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |-> (rsp_rdata_o[DATA_W-KEEP_W-1:0] == '0)); // R2
  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=> $stable(irq_o)); // R6
  AST_BAD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != 4'(BYTES)) |=> rsp_unimpl_o); // R9
endmodule

// File: tb/misc_status_reg_test.sv
module misc_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        v[2], wr[2];
  logic [31:0] ad[2];
  logic [3:0]  sz[2];
  logic [63:0] wd[2];
  logic        rdy[2], unimpl[2], irq[2];
  logic [63:0] rd[2];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  misc_status_reg #(.GEN_B(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v[0]), .req_write_i(wr[0]),
    .req_addr_i(ad[0]), .req_size_i(sz[0]), .req_wdata_i(wd[0]),
    .rsp_ready_o(rdy[0]), .rsp_rdata_o(rd[0]), .rsp_unimpl_o(unimpl[0]), .irq_o(irq[0]));

  misc_status_reg #(.GEN_B(1'b1)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v[1]), .req_write_i(wr[1]),
    .req_addr_i(ad[1]), .req_size_i(sz[1]), .req_wdata_i(wd[1]),
    .rsp_ready_o(rdy[1]), .rsp_rdata_o(rd[1]), .rsp_unimpl_o(unimpl[1]), .irq_o(irq[1]));

  function automatic int base_of(int g);
    return (g == 1) ? 'h6080 : 'h4020;
  endfunction

  function automatic logic [31:0] addr_of(int g, int off);
    return 32'((base_of(g) + off) << 3);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  localparam logic [63:0] KEEP = 64'hFFFF_0000_0000_0000;
  logic [63:0] m_val[2], m_rd[2];
  logic        m_rdy[2], m_un[2];
  string       m_tag[2];

  always @(posedge clk or negedge rst_n) begin
    for (int g = 0; g < 2; g++) begin
      if (!rst_n) begin
        m_val[g] <= '0; m_rd[g] <= '0; m_rdy[g] <= 0; m_un[g] <= 0; m_tag[g] <= "R10";
      end else begin
        int off;
        bit mapped;
        off    = int'(ad[g] >> 3) - base_of(g);
        mapped = v[g] && sz[g] == 4'd8 && off >= 0 && off <= 2;
        m_rdy[g] <= v[g];
        m_un[g]  <= v[g] && !mapped;
        m_rd[g]  <= (mapped && !wr[g] && off == 0) ? m_val[g] : 64'h0;
        m_tag[g] <= !v[g] ? "R7" : (sz[g] != 4'd8) ? "R9" : !mapped ? "R8" :
                    !wr[g] ? "R11" : off == 0 ? "R2" : off == 2 ? "R3" :
                    g == 0 ? "R4" : "R5";
        if (mapped && wr[g]) begin
          case (off)
            0: m_val[g] <= wd[g] & KEEP;
            1: m_val[g] <= (g == 0) ? (m_val[g] & wd[g] & KEEP) : 64'h0;
            default: m_val[g] <= (m_val[g] | wd[g]) & KEEP;
          endcase
        end
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      for (int g = 0; g < 2; g++) begin
        chk({m_tag[g], " ready"}, 64'(rdy[g]), 64'(m_rdy[g]));
        chk({m_tag[g], " unimpl"}, 64'(unimpl[g]), 64'(m_un[g]));
        chk({m_tag[g], " rdata"}, rd[g], m_rd[g]);
        chk("R6 irq level", 64'(irq[g]), 64'(m_val[g][63]));
      end
    end
  end

  task automatic access(int g, bit w, logic [31:0] a, logic [3:0] s, logic [63:0] d);
    @(negedge clk);
    v[g] = 1; wr[g] = w; ad[g] = a; sz[g] = s; wd[g] = d;
    @(negedge clk);
    v[g] = 0; wr[g] = 0;
  endtask

  task automatic read_word(int g, output logic [63:0] q);
    access(g, 0, addr_of(g, 0), 4'd8, 64'h0);
    q = rd[g];
  endtask

  initial begin
    logic [63:0] q;
    for (int g = 0; g < 2; g++) begin
      v[g] = 0; wr[g] = 0; ad[g] = '0; sz[g] = 4'd8; wd[g] = '0;
    end
    repeat (3) @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk("R10 reset irq", 64'(irq[g]), 64'h0);
      chk("R10 reset ready", 64'(rdy[g]), 64'h0);
      chk("R10 reset unimpl", 64'(unimpl[g]), 64'h0);
    end
    rst_n = 1;
    for (int g = 0; g < 2; g++) begin
      read_word(g, q);
      chk("R10 reset value", q, 64'h0);
      access(g, 1, addr_of(g, 0), 4'd8, 64'hDEAD_BEEF_1234_5678);
      chk("R6 irq set by direct write", 64'(irq[g]), 64'h1);
      read_word(g, q);
      chk("R2 direct write masked", q, 64'hDEAD_0000_0000_0000);
      chk("R7 ready with read", 64'(rdy[g]), 64'h1);
      access(g, 0, addr_of(g, 1), 4'd8, 64'h0);
      chk("R7 alias1 reads zero", rd[g], 64'h0);
      access(g, 0, addr_of(g, 2), 4'd8, 64'h0);
      chk("R7 OR alias reads zero", rd[g], 64'h0);
      read_word(g, q);
      chk("R11 reads keep value", q, 64'hDEAD_0000_0000_0000);
      access(g, 1, addr_of(g, 2), 4'd8, 64'h0101_FFFF_FFFF_FFFF);
      read_word(g, q);
      chk("R3 OR merge", q, 64'hDFAD_0000_0000_0000);
      access(g, 1, addr_of(g, 3), 4'd8, 64'h0);
      chk("R8 unimpl above window", 64'(unimpl[g]), 64'h1);
      access(g, 1, addr_of(g, -1), 4'd8, 64'h0);
      chk("R8 unimpl below window", 64'(unimpl[g]), 64'h1);
      access(g, 1, addr_of(1 - g, 0), 4'd8, 64'h0);
      chk("R1 other generation unmapped", 64'(unimpl[g]), 64'h1);
      access(g, 1, addr_of(g, 0), 4'd4, 64'h0);
      chk("R9 bad size flagged", 64'(unimpl[g]), 64'h1);
      read_word(g, q);
      chk("R8 R9 value untouched", q, 64'hDFAD_0000_0000_0000);
      access(g, 1, addr_of(g, 1), 4'd8, 64'h7FFF_FFFF_FFFF_FFFF);
      read_word(g, q);
      if (g == 0) chk("R4 AND alias", q, 64'h5FAD_0000_0000_0000);
      else        chk("R5 clear alias", q, 64'h0);
      chk("R6 irq dropped", 64'(irq[g]), 64'h0);
      access(g, 1, addr_of(g, 2), 4'd8, 64'h8000_0000_0000_0000);
      repeat (4) @(negedge clk);
      chk("R6 irq held as level", 64'(irq[g]), 64'h1);
      access(g, 1, addr_of(g, 1), 4'd8, 64'h0);
      read_word(g, q);
      chk("R4 R5 alias with zero data", q, 64'h0);
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule